// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache between a 32-bit byte-addressed CPU port and a memory port that returns whole lines. With the default geometry it holds 1024 lines of four 32-bit words (16 KB). Each line stores a valid flag, a tag and the line data. A lookup compares the stored tag of the indexed line with the address tag. A two-bit word select then picks one word out of the line.

A read that misses stalls the CPU. The block issues one line-aligned block read, installs the returned line and replays the access, which then hits. Every write goes to memory. A write that hits also updates the cached word. For a write that misses, the `wr_allocate` input chooses the policy at run time. Allocation fetches the line first and then performs the write as a hit. No-allocate sends the word to memory only and leaves the cache unchanged.

The CPU holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` stable until it sees `cpu_ready` high. The access completes at the clock edge where both `cpu_req` and `cpu_ready` are high.

Top module: `dm_wt_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses and causes a block read. While reset is held, `cpu_ready`, `mem_rd_req` and `mem_wr_req` are low.
- R2: The address splits as tag = bits 31:14, line index = bits 13:4, byte offset = bits 3:0. `mem_rd_addr` equals the CPU address with bits 3:0 cleared.
- R3: A read hits when the indexed line is valid and its stored tag equals address bits 31:14. A hit raises `cpu_ready` in the same cycle with no memory request.
- R4: Address bits 3:2 select word k of the line. Word k is bits [32k+31:32k] of the line as delivered on `mem_rd_data`.
- R5: On a read miss, `cpu_ready` stays low while `mem_rd_req` is held until `mem_rd_valid`. The line is installed, and the replayed read returns the memory word.
- R6: On a write hit, the cached word and the memory write start at the same clock edge. A later read of that word hits and returns the new value.
- R7: With `wr_allocate` = 0, a write miss issues only the word write. No block read occurs, and the line keeps its previous tag and data.
- R8: With `wr_allocate` = 1, a write miss first fetches the line and then writes the word to the cache and to memory. A later read of that word hits.
- R9: Two addresses with the same index and different tags (0x14 and 0x8014) evict each other.
- R10: For every write, `cpu_ready` stays low until `mem_wr_ack`. `mem_wr_req`, `mem_wr_addr` and `mem_wr_data` are held until the ack. `mem_wr_addr` is the word-aligned CPU address.
- R11: Block reads and word writes never overlap, and each miss causes exactly one block read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_allocate | input | 1 | 1 = allocate on write miss, 0 = write to memory only |
| cpu_req | input | 1 | Access request, held until completion |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Read word, valid with cpu_ready on reads |
| mem_rd_req | output | 1 | Block read request, held until mem_rd_valid |
| mem_rd_addr | output | 32 | Line-aligned block address |
| mem_rd_valid | input | 1 | Block data strobe |
| mem_rd_data | input | 128 | Returned line, word k in bits [32k+31:32k] |
| mem_wr_req | output | 1 | Word write request, held until mem_wr_ack |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write word |
| mem_wr_ack | input | 1 | Word write accepted |

## Verification
A valid flag that is set wrongly or never set shows at the ports on the next access to that index. The symptoms are stale data with `cpu_ready` high in the request cycle, or an extra block read where a hit was due. A wrong stored tag or index shows within one access as a missed eviction or a spurious miss between conflicting addresses. The conflicting pair 0x14 and 0x8014 exposes both. A wrong word select or fill position shows at once as a wrong `cpu_rdata` word among the four words of one line. A policy fault shows as a block read, or the lack of one, during the stall of the write itself.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int BYTE_SEL_W = 2;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_FILL   = 2'd1,
    ST_WRITE  = 2'd2
  } dmc_state_e;

  // Unsigned field of width w starting at bit lo.
  function automatic logic [ADDR_W-1:0] field_of(input logic [ADDR_W-1:0] a,
                                                 input int lo, input int w);
    logic [ADDR_W-1:0] mask;
    mask = (ADDR_W'(1) << w) - ADDR_W'(1);
    return (a >> lo) & mask;
  endfunction

  // Address with the low nbits cleared.
  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                   input int nbits);
    logic [ADDR_W-1:0] mask;
    mask = (ADDR_W'(1) << nbits) - ADDR_W'(1);
    return a & ~mask;
  endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] look_index,
  input  logic [TAG_W-1:0]   look_tag,
  output logic               look_hit,
  input  logic               install_en,
  input  logic [INDEX_W-1:0] install_index,
  input  logic [TAG_W-1:0]   install_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (install_en) begin
      valid_q[install_index] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install_en) begin
      tag_q[install_index] <= install_tag;
    end
  end

  assign look_hit = valid_q[look_index] && (tag_q[look_index] == look_tag);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
  import dmc_pkg::*;
#(
  parameter int INDEX_W    = 10,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic [INDEX_W-1:0]           index,
  input  logic [$clog2(LINE_WORDS)-1:0] word_sel,
  output logic [WORD_W-1:0]            rd_word,
  input  logic                         fill_en,
  input  logic [LINE_WORDS*WORD_W-1:0] fill_line,
  input  logic                         word_en,
  input  logic [WORD_W-1:0]            word_data
);
  localparam int LINES  = 1 << INDEX_W;
  localparam int LINE_W = LINE_WORDS * WORD_W;
  localparam int WSEL_W = $clog2(LINE_WORDS);

  logic [LINE_W-1:0] line_q [LINES];
  logic [LINE_W-1:0] cur_line;
  logic [WORD_W-1:0] words [LINE_WORDS];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      line_q[index] <= fill_line;
    end else if (word_en) begin
      for (int w = 0; w < LINE_WORDS; w++) begin
        if (word_sel == WSEL_W'(w)) begin
          line_q[index][w*WORD_W +: WORD_W] <= word_data;
        end
      end
    end
  end

  assign cur_line = line_q[index];

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word_split
    assign words[g] = cur_line[g*WORD_W +: WORD_W];
  end

  assign rd_word = words[word_sel];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              wr_allocate,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic              lookup_hit,
  input  logic              mem_rd_valid,
  input  logic              mem_wr_ack,
  output logic              cpu_ready,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic              fill_done,
  output logic              word_wr_en,
  output logic              start_fill,
  output logic              start_write
);
  dmc_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    cpu_ready   = 1'b0;
    mem_rd_req  = 1'b0;
    mem_wr_req  = 1'b0;
    fill_done   = 1'b0;
    word_wr_en  = 1'b0;
    start_fill  = 1'b0;
    start_write = 1'b0;
    case (state_q)
      ST_LOOKUP: begin
        if (cpu_req) begin
          if (!cpu_we) begin
            if (lookup_hit) begin
              cpu_ready = 1'b1;
            end else begin
              start_fill = 1'b1;
              state_d    = ST_FILL;
            end
          end else if (lookup_hit) begin
            word_wr_en  = 1'b1;
            start_write = 1'b1;
            state_d     = ST_WRITE;
          end else if (wr_allocate) begin
            start_fill = 1'b1;
            state_d    = ST_FILL;
          end else begin
            start_write = 1'b1;
            state_d     = ST_WRITE;
          end
        end
      end
      ST_FILL: begin
        mem_rd_req = 1'b1;
        if (mem_rd_valid) begin
          fill_done = 1'b1;
          state_d   = ST_LOOKUP;
        end
      end
      ST_WRITE: begin
        mem_wr_req = 1'b1;
        if (mem_wr_ack) begin
          cpu_ready = 1'b1;
          state_d   = ST_LOOKUP;
        end
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_LOOKUP;
      mem_rd_addr <= '0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      state_q <= state_d;
      if (start_fill) begin
        mem_rd_addr <= align_down(cpu_addr, OFF_W);
      end
      if (start_write) begin
        mem_wr_addr <= align_down(cpu_addr, BYTE_SEL_W);
        mem_wr_data <= cpu_wdata;
      end
    end
  end
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
  import dmc_pkg::*;
#(
  parameter int INDEX_W    = 10,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_allocate,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [31:0]                  cpu_addr,
  input  logic [31:0]                  cpu_wdata,
  output logic                         cpu_ready,
  output logic [31:0]                  cpu_rdata,
  output logic                         mem_rd_req,
  output logic [31:0]                  mem_rd_addr,
  input  logic                         mem_rd_valid,
  input  logic [LINE_WORDS*32-1:0]     mem_rd_data,
  output logic                         mem_wr_req,
  output logic [31:0]                  mem_wr_addr,
  output logic [31:0]                  mem_wr_data,
  input  logic                         mem_wr_ack
);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = WSEL_W + BYTE_SEL_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - OFF_W;

  // Named internal events (observed by the bound checker).
  logic               lookup_hit;
  logic               fill_done;
  logic               word_wr_en;
  logic               start_fill;
  logic               start_write;

  logic [TAG_W-1:0]   addr_tag;
  logic [INDEX_W-1:0] addr_index;
  logic [WSEL_W-1:0]  addr_word;

  assign addr_tag   = TAG_W'(field_of(cpu_addr, OFF_W + INDEX_W, TAG_W));
  assign addr_index = INDEX_W'(field_of(cpu_addr, OFF_W, INDEX_W));
  assign addr_word  = WSEL_W'(field_of(cpu_addr, BYTE_SEL_W, WSEL_W));

  dmc_tag_store #(
    .INDEX_W(INDEX_W),
    .TAG_W  (TAG_W)
  ) u_tags (
    .clk          (clk),
    .rst_n        (rst_n),
    .look_index   (addr_index),
    .look_tag     (addr_tag),
    .look_hit     (lookup_hit),
    .install_en   (fill_done),
    .install_index(addr_index),
    .install_tag  (addr_tag)
  );

  dmc_data_store #(
    .INDEX_W   (INDEX_W),
    .LINE_WORDS(LINE_WORDS)
  ) u_data (
    .clk      (clk),
    .index    (addr_index),
    .word_sel (addr_word),
    .rd_word  (cpu_rdata),
    .fill_en  (fill_done),
    .fill_line(mem_rd_data),
    .word_en  (word_wr_en),
    .word_data(cpu_wdata)
  );

  dmc_ctrl #(
    .OFF_W(OFF_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .wr_allocate (wr_allocate),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .lookup_hit  (lookup_hit),
    .mem_rd_valid(mem_rd_valid),
    .mem_wr_ack  (mem_wr_ack),
    .cpu_ready   (cpu_ready),
    .mem_rd_req  (mem_rd_req),
    .mem_wr_req  (mem_wr_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .fill_done   (fill_done),
    .word_wr_en  (word_wr_en),
    .start_fill  (start_fill),
    .start_write (start_write)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int OFF_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_ready,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_rd_valid,
  input logic        mem_wr_req,
  input logic [31:0] mem_wr_addr,
  input logic [31:0] mem_wr_data,
  input logic        mem_wr_ack,
  input logic        lookup_hit,
  input logic        fill_done,
  input logic        word_wr_en
);
  p_rd_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));

  p_fill_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (!cpu_req || lookup_hit));

  p_stall_on_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !cpu_ready);

  p_rd_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> mem_rd_req);

  p_word_write_starts_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr_en |=> mem_wr_req);

  p_stall_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |-> !cpu_ready);

  p_wr_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=>
      (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_wr_addr_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> (mem_wr_addr[1:0] == 2'b00));

  p_ports_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));
endmodule

bind dm_wt_cache dmc_checker #(.OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_req     (cpu_req),
  .cpu_ready   (cpu_ready),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_rd_valid(mem_rd_valid),
  .mem_wr_req  (mem_wr_req),
  .mem_wr_addr (mem_wr_addr),
  .mem_wr_data (mem_wr_data),
  .mem_wr_ack  (mem_wr_ack),
  .lookup_hit  (lookup_hit),
  .fill_done   (fill_done),
  .word_wr_en  (word_wr_en)
);

// File: tb/dm_wt_cache_tb.sv
module dm_wt_cache_tb;
  localparam int RD_LAT = 3;
  localparam int WR_LAT = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_allocate = 1'b0;
  logic         cpu_req = 1'b0;
  logic         cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cpu_ready;
  logic [31:0]  cpu_rdata;
  logic         mem_rd_req;
  logic [31:0]  mem_rd_addr;
  logic         mem_rd_valid = 1'b0;
  logic [127:0] mem_rd_data = '0;
  logic         mem_wr_req;
  logic [31:0]  mem_wr_addr;
  logic [31:0]  mem_wr_data;
  logic         mem_wr_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int fills = 0;
  int writes = 0;
  bit done = 1'b0;
  logic [31:0] last_rd_addr = '0;
  logic [31:0] last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;
  logic [31:0] wmem [logic [31:0]];

  always #10 clk = ~clk;

  dm_wt_cache u_dut (
    .clk(clk), .rst_n(rst_n), .wr_allocate(wr_allocate),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    if (wmem.exists(w)) return wmem[w];
    return (w * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic logic [127:0] mem_line(input logic [31:0] a);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = mem_word({a[31:4], 4'h0} + 32'(4*k));
    return l;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model: block reads after RD_LAT cycles, write acks after WR_LAT.
  initial begin
    int rd_lat = 0;
    int wr_lat = 0;
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      mem_wr_ack = 1'b0;
      if (rst_n && mem_rd_req) begin
        rd_lat++;
        if (rd_lat == RD_LAT) begin
          mem_rd_data = mem_line(mem_rd_addr);
          mem_rd_valid = 1'b1;
          last_rd_addr = mem_rd_addr;
          fills++;
          rd_lat = 0;
        end
      end else rd_lat = 0;
      if (rst_n && mem_wr_req) begin
        wr_lat++;
        if (wr_lat == WR_LAT) begin
          wmem[mem_wr_addr] = mem_wr_data;
          last_wr_addr = mem_wr_addr;
          last_wr_data = mem_wr_data;
          mem_wr_ack = 1'b1;
          writes++;
          wr_lat = 0;
        end
      end else wr_lat = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int stall);
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
    stall = 0; rd = '0;
    forever begin
      #2;
      if (cpu_ready) begin rd = cpu_rdata; break; end
      @(negedge clk);
      stall++;
      if (stall > 200) begin
        check(1'b0, "R5", "access timeout", 32'(stall), 32'd0);
        break;
      end
    end
    @(posedge clk);
    #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; int st; int f0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'h0;
    @(negedge clk); #2;
    check(!cpu_ready && !mem_rd_req && !mem_wr_req, "R1", "outputs in reset",
          {29'd0, cpu_ready, mem_rd_req, mem_wr_req}, 32'd0);
    cpu_req = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    f0 = fills;
    access(1'b0, 32'h0000_3FF8, '0, rd, st);
    check(fills == f0 + 1, "R1", "first read misses", 32'(fills - f0), 32'd1);
    check(last_rd_addr == 32'h0000_3FF0, "R2", "line address idx 1023", last_rd_addr, 32'h3FF0);
    check(rd == mem_word(32'h3FF8), "R4", "word 2 of line", rd, mem_word(32'h3FF8));
  endtask

  task automatic t_read_miss();
    logic [31:0] rd; int st; int f0;
    f0 = fills;
    access(1'b0, 32'h0000_0014, '0, rd, st);
    check(fills == f0 + 1, "R11", "one block read per miss", 32'(fills - f0), 32'd1);
    check(st > 0, "R5", "stall on miss", 32'(st), 32'd1);
    check(rd == mem_word(32'h14), "R5", "replayed read data", rd, mem_word(32'h14));
    check(last_rd_addr == 32'h10, "R2", "aligned block address", last_rd_addr, 32'h10);
  endtask

  task automatic t_word_select();
    logic [31:0] rd; int st; int f0;
    f0 = fills;
    for (int k = 0; k < 4; k++) begin
      access(1'b0, 32'h10 + 32'(4*k), '0, rd, st);
      check(rd == mem_word(32'h10 + 32'(4*k)), "R4", "word select", rd, mem_word(32'h10 + 32'(4*k)));
      check(st == 0, "R3", "hit has no stall", 32'(st), 32'd0);
    end
    check(fills == f0, "R3", "hits issue no block read", 32'(fills - f0), 32'd0);
  endtask

  task automatic t_conflict();
    logic [31:0] rd; int st; int f0;
    f0 = fills;
    access(1'b0, 32'h0000_8014, '0, rd, st);
    check(rd == mem_word(32'h8014), "R9", "other tag data", rd, mem_word(32'h8014));
    access(1'b0, 32'h0000_0014, '0, rd, st);
    check(fills == f0 + 2, "R9", "eviction causes refetch", 32'(fills - f0), 32'd2);
    check(rd == mem_word(32'h14), "R9", "refetched data", rd, mem_word(32'h14));
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int st; int f0; int w0;
    f0 = fills; w0 = writes;
    access(1'b1, 32'h0000_0018, 32'hDEAD_0018, rd, st);
    check(writes == w0 + 1, "R6", "write-through to memory", 32'(writes - w0), 32'd1);
    check(last_wr_addr == 32'h18 && last_wr_data == 32'hDEAD_0018, "R6", "memory word",
          last_wr_data, 32'hDEAD_0018);
    check(st >= WR_LAT, "R10", "ready waits for ack", 32'(st), 32'(WR_LAT));
    access(1'b0, 32'h0000_0018, '0, rd, st);
    check(rd == 32'hDEAD_0018 && st == 0, "R6", "cached word updated", rd, 32'hDEAD_0018);
    check(fills == f0, "R6", "no block read", 32'(fills - f0), 32'd0);
  endtask

  task automatic t_write_noalloc();
    logic [31:0] rd; int st; int f0; int w0;
    wr_allocate = 1'b0;
    f0 = fills; w0 = writes;
    access(1'b1, 32'h0000_801B, 32'h5A5A_801B, rd, st);
    check(fills == f0, "R7", "no block read on miss", 32'(fills - f0), 32'd0);
    check(writes == w0 + 1 && last_wr_addr == 32'h8018, "R10", "word-aligned write", last_wr_addr, 32'h8018);
    access(1'b0, 32'h0000_0018, '0, rd, st);
    check(rd == 32'hDEAD_0018 && fills == f0, "R7", "line left untouched", rd, 32'hDEAD_0018);
    access(1'b0, 32'h0000_8018, '0, rd, st);
    check(fills == f0 + 1, "R7", "read of written address misses", 32'(fills - f0), 32'd1);
    check(rd == 32'h5A5A_801B, "R7", "memory holds written word", rd, 32'h5A5A_801B);
  endtask

  task automatic t_write_alloc();
    logic [31:0] rd; int st; int f0; int w0;
    wr_allocate = 1'b1;
    f0 = fills; w0 = writes;
    access(1'b1, 32'h0002_0024, 32'hA110_C024, rd, st);
    check(fills == f0 + 1 && writes == w0 + 1, "R8", "fetch then write",
          32'(fills - f0), 32'd1);
    access(1'b0, 32'h0002_0024, '0, rd, st);
    check(rd == 32'hA110_C024 && st == 0, "R8", "allocated word hits", rd, 32'hA110_C024);
    access(1'b0, 32'h0002_002C, '0, rd, st);
    check(rd == mem_word(32'h2002C) && fills == f0 + 1, "R8", "rest of line installed",
          rd, mem_word(32'h2002C));
    wr_allocate = 1'b0;
  endtask

  initial begin
    t_reset();
    t_read_miss();
    t_word_select();
    t_conflict();
    t_write_hit();
    t_write_noalloc();
    t_write_alloc();
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule